// File: doc/BRIEF.md
# Clock Output Gating Controller

This block governs a bank of system clock outputs: host-processor, memory, 66 MHz, peripheral-bus, 48 MHz serial-bus, reference and interrupt-controller clocks. Every clock input is treated as a level and oversampled by the block's fast clock `clk`. Each output is modelled as a value bit plus one shared output enable. Three select inputs choose the operating mode. The first is a fully floating bank. The second is a test mode, in which every output is an integer division of an externally driven test clock. The third is the run mode, in which synthesized clocks arriving on input pins are passed through. Frequency synthesis itself lies outside the block.

Behind the mode selection sit three gating layers. The first is a strap sampled during reset, which sets the interrupt-controller rate as either the peripheral rate or half of it. The second is one enable bit per output. The third is an active-low power-down request. That request is qualified on the processor clock and takes effect only after two consecutive low samples. Every gate opens and closes only while its clock is low. As a result, stopping and restarting never produces a shortened pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: When `sel_ext`=0 and `sel_pins`=00, `clk_oe` is 0 and every `clk_out` bit reads 0.
- R2: When `sel_ext`=0 and `sel_pins`=01 (test mode), the outputs divide `tst_clk` as follows: processor /2, memory /2, 66 MHz /3, peripheral /8, serial-bus /2, reference /1.
- R3: The interrupt-controller outputs depend on the strap. In test mode they run at `tst_clk`/16 with the strap latched low and `tst_clk`/8 with it latched high. In run mode they run at half the `syn_pci` rate (strap low) or at the `syn_pci` rate (strap high).
- R4: `strap_in` is captured only while `rst_n` is low. Changes after reset leave the interrupt-controller rate unchanged.
- R5: In every other select combination (run mode), each output follows its synthesized input: `syn_cpu`, `syn_sdram`, `syn_m66`, `syn_pci`, `syn_usb` and `syn_ref`.
- R6: `pwrdn_n` stops the outputs only after it has been sampled low on two consecutive rising edges of the processor clock. A single low sample has no effect.
- R7: While stopped, outputs are held low with `clk_oe` still 1. A gated output falls only together with its source clock, so every high pulse is full length.
- R8: Power-down is released after two consecutive high samples on processor clock rising edges. Each output then resumes at a rising edge of its source with a full-length high phase.
- R9: Each bit of `out_en` gates the matching `clk_out` bit. A cleared bit drives that output low from its next low phase while `clk_oe` stays 1. The bit map is: 0 reference; 1..3 processor; 4..12 memory; 13..14 66 MHz; 15..22 peripheral; 23..24 serial-bus; 25..26 interrupt-controller.
- R10: In test mode the even dividers give exactly 50 % duty cycle. The divide-by-3 output stays between 33 % and 67 %.
- R11: While `rst_n` is low, every `clk_out` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| sel_pins | input | 2 | Mode select pins |
| sel_ext | input | 1 | Extra mode select bit from configuration |
| strap_in | input | 1 | Interrupt-controller rate strap |
| pwrdn_n | input | 1 | Active-low power-down request |
| out_en | input | 27 | Per-output enable bits (map in R9) |
| tst_clk | input | 1 | External test clock |
| syn_cpu | input | 1 | Synthesized processor clock |
| syn_sdram | input | 1 | Synthesized memory clock |
| syn_m66 | input | 1 | Synthesized 66 MHz clock |
| syn_pci | input | 1 | Synthesized peripheral clock |
| syn_usb | input | 1 | Synthesized serial-bus clock |
| syn_ref | input | 1 | Reference clock |
| clk_out | output | 27 | Output clock values (map in R9) |
| clk_oe | output | 1 | Shared output enable; 0 means floating |

## Verification
The assertions watch three rules on every cycle:
- A gated clock rises or falls only in step with its source clock, which makes runt pulses impossible.
- The stop flag sets only after two low samples on processor edges and clears only after two high samples.
- Divider outputs move only on test-clock edges, the strap holds after reset, and a floating bank reads zero.

The division ratios, the strap-dependent interrupt rate, the duty cycles, the enable bit map and the full stop/resume sequence can only be shown by the bench. It counts edges and high samples over windows spanning whole periods.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  typedef enum logic [1:0] {MODE_HIZ, MODE_TEST, MODE_RUN} mode_e;

  // Group indices of the per-group source vector
  localparam int G_REF  = 0;
  localparam int G_CPU  = 1;
  localparam int G_SDR  = 2;
  localparam int G_M66  = 3;
  localparam int G_PCI  = 4;
  localparam int G_USB  = 5;
  localparam int G_APIC = 6;
  localparam int N_GRP  = 7;

  function automatic mode_e decode_mode(input logic sel_ext, input logic [1:0] sel_pins);
    if (!sel_ext && sel_pins == 2'b00) return MODE_HIZ;
    if (!sel_ext && sel_pins == 2'b01) return MODE_TEST;
    return MODE_RUN;
  endfunction

  // Map a flat output index to its group, given the group sizes
  function automatic int out_group(input int i, input int n_cpu, input int n_sdr,
                                   input int n_m66, input int n_pci, input int n_usb);
    int base;
    base = 1;
    if (i < base) return G_REF;
    base += n_cpu;
    if (i < base) return G_CPU;
    base += n_sdr;
    if (i < base) return G_SDR;
    base += n_m66;
    if (i < base) return G_M66;
    base += n_pci;
    if (i < base) return G_PCI;
    base += n_usb;
    if (i < base) return G_USB;
    return G_APIC;
  endfunction

  // Divider counter step and output level for a count
  function automatic int div_step(input int cnt, input int div);
    return (cnt >= div - 1) ? 0 : cnt + 1;
  endfunction

  function automatic logic div_level(input int cnt, input int div);
    return cnt < (div / 2);
  endfunction

endpackage

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic q
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;

  assign cnt_n = CW'(div_step(int'(cnt), DIV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CW'(DIV - 1);
      q   <= 1'b0;
    end else if (tick) begin
      cnt <= cnt_n;
      q   <= div_level(int'(cnt_n), DIV);
    end
  end

  // R2: a divided output only moves on a test-clock rising edge
  assert_div_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(tick));

endmodule

// File: rtl/clkout_pdsync.sv
module clkout_pdsync (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_lvl,
  input  logic pwrdn_n,
  output logic stop
);
  logic cpu_d;
  logic low1;
  logic cpu_rise;

  assign cpu_rise = cpu_lvl & ~cpu_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_d <= 1'b0;
      low1  <= 1'b0;
      stop  <= 1'b0;
    end else begin
      cpu_d <= cpu_lvl;
      if (cpu_rise) begin
        low1 <= ~pwrdn_n;
        if (!pwrdn_n && low1)      stop <= 1'b1;
        else if (pwrdn_n && !low1) stop <= 1'b0;
      end
    end
  end

  assert_pd_two_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rise && !pwrdn_n && low1) |=> stop);

  assert_pd_on_cpu_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop) |-> $past(cpu_rise));

  assert_pd_two_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rise && pwrdn_n && !low1) |=> !stop);

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic allow,
  output logic g
);
  logic open_q;

  // The gate state may only change while the source is low
  always_ff @(posedge clk) begin
    if (!rst_n)   open_q <= 1'b0;
    else if (!src) open_q <= allow;
  end

  assign g = src & open_q;

  assert_no_runt_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g) |-> $rose(src));

  assert_no_runt_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(g) |-> $fell(src));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int N_CPU       = 3,
  parameter int N_SDR       = 9,
  parameter int N_M66       = 2,
  parameter int N_PCI       = 8,
  parameter int N_USB       = 2,
  parameter int N_APIC      = 2,
  parameter int DIV_CPU     = 2,
  parameter int DIV_SDR     = 2,
  parameter int DIV_M66     = 3,
  parameter int DIV_PCI     = 8,
  parameter int DIV_USB     = 2,
  parameter int DIV_APIC_LO = 16,
  parameter int DIV_APIC_HI = 8,
  localparam int NOUT = 1 + N_CPU + N_SDR + N_M66 + N_PCI + N_USB + N_APIC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_pins,
  input  logic            sel_ext,
  input  logic            strap_in,
  input  logic            pwrdn_n,
  input  logic [NOUT-1:0] out_en,
  input  logic            tst_clk,
  input  logic            syn_cpu,
  input  logic            syn_sdram,
  input  logic            syn_m66,
  input  logic            syn_pci,
  input  logic            syn_usb,
  input  logic            syn_ref,
  output logic [NOUT-1:0] clk_out,
  output logic            clk_oe
);
  localparam int N_DIV = 7;
  localparam int DIV_TAB [N_DIV] = '{DIV_CPU, DIV_SDR, DIV_M66, DIV_PCI, DIV_USB,
                                     DIV_APIC_LO, DIV_APIC_HI};

  mode_e mode;
  logic  strap_q;
  logic  tclk_q, tclk_d, tick, ref_t;
  logic  [N_DIV-1:0] div_q;
  logic  [5:0] nrm_q;
  logic  pci_prev, pci_half;
  logic  [N_GRP-1:0] grp_test, grp_run, grp_src;
  logic  stop;
  logic  [NOUT-1:0] gated;

  assign mode   = decode_mode(sel_ext, sel_pins);
  assign clk_oe = (mode != MODE_HIZ);

  // Strap captured only during reset
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  // Test clock sampling and edge detect
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tclk_q <= 1'b0;
      tclk_d <= 1'b0;
      ref_t  <= 1'b0;
    end else begin
      tclk_q <= tst_clk;
      tclk_d <= tclk_q;
      ref_t  <= tclk_q;
    end
  end
  assign tick = tclk_q & ~tclk_d;

  for (genvar k = 0; k < N_DIV; k++) begin : g_div
    clkout_div #(.DIV(DIV_TAB[k])) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .q    (div_q[k])
    );
  end

  // Run-mode sources: registered synthesized clocks, plus half-rate peripheral clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrm_q    <= '0;
      pci_prev <= 1'b0;
      pci_half <= 1'b0;
    end else begin
      nrm_q    <= {syn_ref, syn_usb, syn_pci, syn_m66, syn_sdram, syn_cpu};
      pci_prev <= nrm_q[3];
      if (nrm_q[3] && !pci_prev) pci_half <= ~pci_half;
    end
  end

  always_comb begin
    grp_test[G_REF]  = ref_t;
    grp_test[G_CPU]  = div_q[0];
    grp_test[G_SDR]  = div_q[1];
    grp_test[G_M66]  = div_q[2];
    grp_test[G_PCI]  = div_q[3];
    grp_test[G_USB]  = div_q[4];
    grp_test[G_APIC] = strap_q ? div_q[6] : div_q[5];

    grp_run[G_REF]   = nrm_q[5];
    grp_run[G_CPU]   = nrm_q[0];
    grp_run[G_SDR]   = nrm_q[1];
    grp_run[G_M66]   = nrm_q[2];
    grp_run[G_PCI]   = nrm_q[3];
    grp_run[G_USB]   = nrm_q[4];
    grp_run[G_APIC]  = strap_q ? nrm_q[3] : pci_half;

    grp_src = (mode == MODE_TEST) ? grp_test : grp_run;
  end

  clkout_pdsync u_pd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu_lvl(grp_src[G_CPU]),
    .pwrdn_n(pwrdn_n),
    .stop   (stop)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int GRP = out_group(i, N_CPU, N_SDR, N_M66, N_PCI, N_USB);
    clkout_gate u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (grp_src[GRP]),
      .allow(~stop & out_en[i]),
      .g    (gated[i])
    );
    assign clk_out[i] = clk_oe & gated[i];
  end

  assert_hiz_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> (clk_out == '0));

  assert_strap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

endmodule

// File: tb/clkout_ctrl_tb_top.sv
module clkout_ctrl_tb_top;
  localparam int NOUT = 27;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      sel_pins;
  logic            sel_ext;
  logic            strap_in;
  logic            pwrdn_n;
  logic [NOUT-1:0] out_en;
  logic            tst_clk, syn_cpu, syn_sdram, syn_m66, syn_pci, syn_usb, syn_ref;
  logic [NOUT-1:0] clk_out;
  logic            clk_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkout_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .sel_ext(sel_ext),
    .strap_in(strap_in), .pwrdn_n(pwrdn_n), .out_en(out_en), .tst_clk(tst_clk),
    .syn_cpu(syn_cpu), .syn_sdram(syn_sdram), .syn_m66(syn_m66), .syn_pci(syn_pci),
    .syn_usb(syn_usb), .syn_ref(syn_ref), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  // Free-running stimulus clocks, changed on the falling edge
  int gc = 0;
  always @(negedge clk) begin
    gc = gc + 1;
    tst_clk   = (gc % 4) < 2;
    syn_cpu   = (gc % 6) < 3;
    syn_sdram = (gc % 6) < 3;
    syn_m66   = (gc % 8) < 4;
    syn_pci   = (gc % 12) < 6;
    syn_usb   = (gc % 10) < 5;
    syn_ref   = (gc % 14) < 7;
  end

  // Group of each output bit, per the map in R9
  function automatic int grp_of(int i);
    if (i == 0) return 0;
    if (i <= 3) return 1;
    if (i <= 12) return 2;
    if (i <= 14) return 3;
    if (i <= 22) return 4;
    if (i <= 24) return 5;
    return 6;
  endfunction

  // Scoreboard: kind 0 = rising edges, 1 = high samples, 2 = shortest full high run
  typedef struct {string req; int idx; int kind; int lo; int hi;} exp_t;
  exp_t sb[$];

  int rises [NOUT];
  int highs [NOUT];
  int minrun[NOUT];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(string req, int idx, int kind, int lo, int hi);
    exp_t e;
    e.req = req; e.idx = idx; e.kind = kind; e.lo = lo; e.hi = hi;
    sb.push_back(e);
  endtask

  task automatic push_rates(string req, int r0, int r1, int r2, int r3, int r4, int r5, int r6);
    int r [7];
    r = '{r0, r1, r2, r3, r4, r5, r6};
    for (int i = 0; i < NOUT; i++) push(req, i, 0, r[grp_of(i)], r[grp_of(i)]);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) step();
  endtask

  // Monitor: measure a window, then pop and compare every queued expectation
  task automatic run_window(int w);
    logic [NOUT-1:0] prev;
    bit inrun [NOUT];
    int runlen[NOUT];
    for (int i = 0; i < NOUT; i++) begin
      rises[i] = 0; highs[i] = 0; minrun[i] = 1000000; inrun[i] = 0; runlen[i] = 0;
    end
    step();
    prev = clk_out;
    for (int c = 0; c < w; c++) begin
      step();
      for (int i = 0; i < NOUT; i++) begin
        if (clk_out[i]) begin
          highs[i]++;
          if (!prev[i]) begin
            rises[i]++; inrun[i] = 1; runlen[i] = 1;
          end else if (inrun[i]) runlen[i]++;
        end else if (prev[i] && inrun[i]) begin
          if (runlen[i] < minrun[i]) minrun[i] = runlen[i];
          inrun[i] = 0;
        end
      end
      prev = clk_out;
    end
    while (sb.size() > 0) begin
      exp_t e;
      int act;
      e = sb.pop_front();
      act = (e.kind == 0) ? rises[e.idx] : (e.kind == 1) ? highs[e.idx] : minrun[e.idx];
      checks++;
      if (act < e.lo || act > e.hi) begin
        errors++;
        $display("FAIL %s out[%0d] kind %0d actual %0d expected %0d..%0d",
                 e.req, e.idx, e.kind, act, e.lo, e.hi);
      end
    end
  endtask

  task automatic do_reset(bit strap);
    rst_n = 1'b0;
    strap_in = strap;
    wait_cyc(6);
    chk("R11 reset outputs low", int'(clk_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    sel_pins = 2'b01; sel_ext = 1'b0; pwrdn_n = 1'b1; out_en = '1;
    do_reset(1'b0);

    // Test mode, strap low
    wait_cyc(100);
    chk("R2 oe in test mode", int'(clk_oe), 1);
    push_rates("R2 R3 test ratios strap low", 192, 96, 96, 64, 24, 96, 12);
    push("R10 cpu duty 50", 1, 1, 384, 384);
    push("R10 pci duty 50", 15, 1, 384, 384);
    push("R10 div3 duty", 13, 1, 768 * 33 / 100, 768 * 67 / 100);
    run_window(768);

    // Floating bank
    @(negedge clk); sel_pins = 2'b00;
    wait_cyc(3);
    chk("R1 oe low", int'(clk_oe), 0);
    chk("R1 outputs zero", int'(clk_out), 0);

    // Run mode, strap low
    @(negedge clk); sel_ext = 1'b1;
    wait_cyc(100);
    push_rates("R5 R3 run rates strap low", 60, 140, 140, 105, 70, 84, 35);
    run_window(840);

    // Strap change after reset has no effect
    @(negedge clk); strap_in = 1'b1;
    wait_cyc(50);
    push("R4 strap ignored after reset", 25, 0, 35, 35);
    push("R4 strap ignored after reset", 26, 0, 35, 35);
    run_window(840);

    // Per-output enables
    @(negedge clk); out_en[5] = 1'b0; out_en[16] = 1'b0;
    wait_cyc(50);
    push_rates("R9 enable map", 60, 140, 140, 105, 70, 84, 35);
    void'(sb.pop_back()); // rebuild list with disabled bits
    sb.delete();
    for (int i = 0; i < NOUT; i++) begin
      int r [7];
      r = '{60, 140, 140, 105, 70, 84, 35};
      push("R9 enable map", i, 0, (i == 5 || i == 16) ? 0 : r[grp_of(i)],
           (i == 5 || i == 16) ? 0 : r[grp_of(i)]);
    end
    run_window(840);
    chk("R9 oe stays high", int'(clk_oe), 1);
    @(negedge clk); out_en = '1;
    wait_cyc(50);

    // Single low sample of power-down is ignored
    @(negedge clk); pwrdn_n = 1'b0;
    repeat (4) @(negedge clk);
    pwrdn_n = 1'b1;
    push_rates("R6 single low sample ignored", 60, 140, 140, 105, 70, 84, 35);
    run_window(840);

    // Power-down entry, no shortened pulses
    push("R7 cpu full pulses", 1, 2, 3, 3);
    push("R7 m66 full pulses", 13, 2, 4, 4);
    push("R7 pci full pulses", 15, 2, 6, 6);
    fork
      run_window(300);
      begin repeat (60) @(negedge clk); pwrdn_n = 1'b0; end
    join
    wait_cyc(50);
    push_rates("R6 R7 stopped", 0, 0, 0, 0, 0, 0, 0);
    run_window(840);
    chk("R7 oe during stop", int'(clk_oe), 1);

    // Release
    push("R8 cpu clean resume", 1, 2, 3, 3);
    push("R8 pci clean resume", 15, 2, 6, 6);
    push("R8 usb clean resume", 23, 2, 5, 5);
    fork
      run_window(300);
      begin repeat (60) @(negedge clk); pwrdn_n = 1'b1; end
    join
    wait_cyc(50);
    push_rates("R8 resumed rates", 60, 140, 140, 105, 70, 84, 35);
    run_window(840);

    // Strap latched high
    do_reset(1'b1);
    strap_in = 1'b0;
    sel_ext = 1'b0; sel_pins = 2'b10;
    wait_cyc(100);
    push_rates("R3 R5 run rates strap high", 60, 140, 140, 105, 70, 84, 70);
    run_window(840);
    @(negedge clk); sel_pins = 2'b01;
    wait_cyc(100);
    push_rates("R2 R3 test ratios strap high", 192, 96, 96, 64, 24, 96, 24);
    run_window(768);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule